// File: doc/BRIEF.md
# Recirculating Dual Serial Transmitter

This block is the output stage of a channel-multiplexed speech transcoder. Each time the frame strobe falls, it captures a finished result word together with its transfer direction, code rate, companding law and channel-enable flag. During the following strobe-high window it sends that word out MSB first. There are two serial outputs. The 8-bit companded sample leaves on the sample clock. The 2-to-5-bit compressed code leaves on the code clock, placed in a 4-bit or 5-bit slot.

The MSB is presented as soon as the strobe rises. Each later bit follows a rising edge of the serial clock that belongs to the active output. If the window holds more clock edges than the word has bits, the pattern starts again from the MSB. When the channel is disabled, fixed idle patterns are sent in place of the word.

Each output is modelled as a data line plus an enable: an enable of 0 means the pin floats. At most one enable is high at a time. Both enables are low while the strobe is low and during reset. All inputs are taken to be synchronous to `clk`. The serial clocks and the strobe are sampled on `clk` edges, and their rising and falling edges are found by comparing each sample with the one before.

Top module: `recirc_ser_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe fall, `pcm_oe` and `code_oe` are both 0.
- R2: On a strobe fall, the block captures `dir_in`, `rate_in`, `law_in`, `en_in`, `pcm_in` and `code_in`. The next window sends only these captured values, whatever happens on those inputs afterwards.
- R3: One `clk` cycle after the strobe rises, the active output drives the MSB of the captured word.
- R4: Each rising edge of the active serial clock inside a window moves the active output to the next lower bit, one `clk` cycle later. Between edges the output holds its value.
- R5: The sample output repeats with a period of 8 bits. After the seventh rising edge, the next edge brings the MSB back.
- R6: The code output uses a 4-bit slot, sent MSB first and repeated every 4 bits, for three rate codes. `rate_in` = 00 sends code[3:0]. `rate_in` = 01 sends code[2:0] followed by one 0. `rate_in` = 10 sends code[1:0] followed by two 0s.
- R7: With `rate_in` = 11, the code output sends code[4:0] and repeats every 5 bits.
- R8: While the strobe is low, both enables are 0.
- R9: When the captured direction is 0, only the sample output drives (`pcm_oe` = 1). When it is 1, only the code output drives (`code_oe` = 1). The two enables are never high together.
- R10: When the captured enable is 0, the code slot is all zeros. The sample word is 8'hFF when `law_in` = 0 and 8'hD5 when `law_in` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Frame strobe: falling edge loads, high level opens the window |
| pcm_sclk | input | 1 | Serial clock for the sample output |
| code_sclk | input | 1 | Serial clock for the code output |
| dir_in | input | 1 | Direction: 0 selects the sample output, 1 selects the code output |
| rate_in | input | 2 | Code rate: 00, 01 and 10 use a 4-bit slot, 11 uses a 5-bit slot |
| law_in | input | 1 | Idle sample law: 0 gives FF, 1 gives D5 |
| en_in | input | 1 | Channel enable; 0 sends the idle patterns |
| pcm_in | input | PCM_W | Companded sample word |
| code_in | input | CODE_W | Compressed code word, right-aligned |
| pcm_sd | output | 1 | Sample serial data |
| pcm_oe | output | 1 | Sample output drive enable |
| code_sd | output | 1 | Code serial data |
| code_oe | output | 1 | Code output drive enable |

## Verification
The assertions check four things on every cycle:
- the two enables are never high together;
- both enables drop whenever the strobe was low;
- an enable can only rise after the strobe was high;
- each data line holds its value inside a window when its clock shows no rising edge.

Only the bench scenarios can show that the right bit appears at each position: the MSB at the strobe rise, the wrap after 8, 4 or 5 bits, the zero filler in the narrow code rates, and the idle words for each law. They also show that inputs changed after the load have no effect on the window.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
    localparam int PCM_BITS  = 8;
    localparam int CODE_BITS = 5;

    typedef enum logic [1:0] {
        RATE_NARROW4 = 2'b00,
        RATE_NARROW3 = 2'b01,
        RATE_NARROW2 = 2'b10,
        RATE_WIDE5   = 2'b11
    } rate_e;

    localparam logic [PCM_BITS-1:0] IDLE_LAW0 = 8'hFF;
    localparam logic [PCM_BITS-1:0] IDLE_LAW1 = 8'hD5;
endpackage

// File: rtl/rsx_word_fmt.sv
module rsx_word_fmt
    import rsx_pkg::*;
#(
    parameter int PCM_W  = PCM_BITS,
    parameter int CODE_W = CODE_BITS,
    parameter logic [PCM_W-1:0] IDLE0 = IDLE_LAW0,
    parameter logic [PCM_W-1:0] IDLE1 = IDLE_LAW1,
    localparam int LEN_W = $clog2(CODE_W + 1)
) (
    input  logic [PCM_W-1:0]  pcm_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic [1:0]        rate_in,
    input  logic              law_in,
    input  logic              en_in,
    output logic [PCM_W-1:0]  pcm_word,
    output logic [CODE_W-1:0] code_slot,
    output logic [LEN_W-1:0]  code_len
);
    // number of significant code bits for each rate
    function automatic int sig_bits(input logic [1:0] r);
        case (rate_e'(r))
            RATE_WIDE5:   return CODE_W;
            RATE_NARROW4: return CODE_W - 1;
            RATE_NARROW3: return CODE_W - 2;
            default:      return CODE_W - 3;
        endcase
    endfunction

    always_comb begin
        int nb;
        logic [CODE_W-1:0] mask;
        nb   = sig_bits(rate_in);
        mask = CODE_W'((1 << nb) - 1);
        code_len = (rate_e'(rate_in) == RATE_WIDE5) ? LEN_W'(CODE_W) : LEN_W'(CODE_W - 1);
        if (en_in) begin
            pcm_word  = pcm_in;
            code_slot = (code_in & mask) << (CODE_W - nb);
        end else begin
            pcm_word  = law_in ? IDLE1 : IDLE0;
            code_slot = '0;
        end
    end
endmodule

// File: rtl/rsx_bit_ptr.sv
module rsx_bit_ptr #(
    parameter int MAXLEN = 8,
    localparam int LW = $clog2(MAXLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [LW-1:0] len,
    output logic [LW-1:0] idx
);
    typedef struct packed {
        logic [LW-1:0] pos;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d.pos = '0;
        end else if (adv) begin
            ptr_d.pos = (ptr_q.pos >= len - LW'(1)) ? '0 : ptr_q.pos + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign idx = ptr_q.pos;
endmodule

// File: rtl/recirc_ser_tx.sv
module recirc_ser_tx
    import rsx_pkg::*;
#(
    parameter int PCM_W  = PCM_BITS,
    parameter int CODE_W = CODE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              pcm_sclk,
    input  logic              code_sclk,
    input  logic              dir_in,
    input  logic [1:0]        rate_in,
    input  logic              law_in,
    input  logic              en_in,
    input  logic [PCM_W-1:0]  pcm_in,
    input  logic [CODE_W-1:0] code_in,
    output logic              pcm_sd,
    output logic              pcm_oe,
    output logic              code_sd,
    output logic              code_oe
);
    localparam int PLW = $clog2(PCM_W + 1);
    localparam int CLW = $clog2(CODE_W + 1);

    typedef struct packed {
        logic              strb;
        logic              pclk;
        logic              cclk;
        logic              loaded;
        logic              dir;
        logic [PCM_W-1:0]  pcm_word;
        logic [CODE_W-1:0] code_slot;
        logic [CLW-1:0]    code_len;
    } tx_t;

    tx_t s_d, s_q;

    logic [PCM_W-1:0]  fmt_pcm;
    logic [CODE_W-1:0] fmt_slot;
    logic [CLW-1:0]    fmt_len;
    logic              fall, p_adv, c_adv;
    logic [PLW-1:0]    pidx;
    logic [CLW-1:0]    cidx;

    rsx_word_fmt #(.PCM_W(PCM_W), .CODE_W(CODE_W)) u_fmt (
        .pcm_in   (pcm_in),
        .code_in  (code_in),
        .rate_in  (rate_in),
        .law_in   (law_in),
        .en_in    (en_in),
        .pcm_word (fmt_pcm),
        .code_slot(fmt_slot),
        .code_len (fmt_len)
    );

    assign fall  = s_q.strb & ~strobe;
    assign p_adv = strobe & pcm_sclk  & ~s_q.pclk;
    assign c_adv = strobe & code_sclk & ~s_q.cclk;

    rsx_bit_ptr #(.MAXLEN(PCM_W)) u_pptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fall),
        .adv  (p_adv),
        .len  (PLW'(PCM_W)),
        .idx  (pidx)
    );

    rsx_bit_ptr #(.MAXLEN(CODE_W)) u_cptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fall),
        .adv  (c_adv),
        .len  (s_q.code_len),
        .idx  (cidx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.strb = strobe;
        s_d.pclk = pcm_sclk;
        s_d.cclk = code_sclk;
        if (fall) begin
            s_d.loaded    = 1'b1;
            s_d.dir       = dir_in;
            s_d.pcm_word  = fmt_pcm;
            s_d.code_slot = fmt_slot;
            s_d.code_len  = fmt_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        pcm_oe  = s_q.strb & s_q.loaded & ~s_q.dir;
        code_oe = s_q.strb & s_q.loaded &  s_q.dir;
        pcm_sd  = pcm_oe  & s_q.pcm_word[PCM_W - 1 - int'(pidx)];
        code_sd = code_oe & s_q.code_slot[CODE_W - 1 - int'(cidx)];
    end
endmodule

// File: rtl/recirc_ser_tx_chk.sv
module recirc_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic strobe,
    input logic pcm_sclk,
    input logic code_sclk,
    input logic pcm_sd,
    input logic pcm_oe,
    input logic code_sd,
    input logic code_oe
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_FLOAT: assert (!pcm_oe && !code_oe); // R1
        end
    end

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(pcm_oe && code_oe)); // R9

    AST_FLOAT_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe) |-> (!pcm_oe && !code_oe)); // R8

    AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pcm_oe) || $rose(code_oe)) |-> $past(strobe)); // R8

    AST_PCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe) && !(pcm_sclk && !$past(pcm_sclk))) |=> $stable(pcm_sd)); // R4

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe) && !(code_sclk && !$past(code_sclk))) |=> $stable(code_sd)); // R4
endmodule

bind recirc_ser_tx recirc_ser_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .pcm_sclk (pcm_sclk),
    .code_sclk(code_sclk),
    .pcm_sd   (pcm_sd),
    .pcm_oe   (pcm_oe),
    .code_sd  (code_sd),
    .code_oe  (code_oe)
);

// File: tb/tb_recirc_ser_tx.sv
module tb_recirc_ser_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, strobe, pcm_sclk, code_sclk, dir_in, law_in, en_in;
    logic [1:0] rate_in;
    logic [7:0] pcm_in;
    logic [4:0] code_in;
    logic       pcm_sd, pcm_oe, code_sd, code_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    recirc_ser_tx dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pcm_sclk(pcm_sclk),
        .code_sclk(code_sclk), .dir_in(dir_in), .rate_in(rate_in),
        .law_in(law_in), .en_in(en_in), .pcm_in(pcm_in), .code_in(code_in),
        .pcm_sd(pcm_sd), .pcm_oe(pcm_oe), .code_sd(code_sd), .code_oe(code_oe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference copy of what the last strobe fall should have captured
    bit       m_loaded = 0;
    bit       m_dir, m_en;
    bit [7:0] m_pcm;
    bit [4:0] m_slot;
    int       m_len;

    function automatic bit [7:0] ref_pcm(bit [7:0] w, bit law, bit en);
        if (en) return w;
        return law ? 8'hD5 : 8'hFF;
    endfunction

    function automatic bit [4:0] ref_slot(bit [4:0] c, bit [1:0] r, bit en);
        if (!en) return 5'b0;
        case (r)
            2'b00:   return {c[3:0], 1'b0};
            2'b01:   return {c[2:0], 2'b0};
            2'b10:   return {c[1:0], 3'b0};
            default: return c;
        endcase
    endfunction

    function automatic int ref_len(bit [1:0] r);
        return (r == 2'b11) ? 5 : 4;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // present a word and drop the strobe; R2 capture
    task automatic load(bit [7:0] w, bit [4:0] c, bit d, bit [1:0] r, bit law, bit en);
        @(negedge clk);
        pcm_in = w; code_in = c; dir_in = d; rate_in = r; law_in = law; en_in = en;
        strobe = 1'b0;
        wait_n(3);
        m_loaded = 1; m_dir = d; m_en = en;
        m_pcm  = ref_pcm(w, law, en);
        m_slot = ref_slot(c, r, en);
        m_len  = ref_len(r);
        chk("R8", {6'b0, pcm_oe, code_oe}, 8'h00);
        // disturb inputs after the load: must not affect the window (R2)
        pcm_in = ~w; code_in = ~c; dir_in = ~d; rate_in = ~r; law_in = ~law; en_in = ~en;
    endtask

    task automatic sample(int k);
        string tag;
        bit ep, ec, bp, bc;
        ep = m_loaded && !m_dir;
        ec = m_loaded &&  m_dir;
        bp = ep ? m_pcm[7 - (k % 8)] : 1'b0;
        bc = ec ? m_slot[4 - (k % m_len)] : 1'b0;
        if (!m_loaded)      tag = "R1";
        else if (!m_en)     tag = "R10";
        else if (k == 0)    tag = "R2/R3";
        else if (m_dir)     tag = (m_len == 5) ? "R7" : "R6";
        else                tag = (k >= 8) ? "R5" : "R4";
        chk("R9", {6'b0, pcm_oe, code_oe}, {6'b0, ep, ec});
        chk(tag, {6'b0, pcm_sd, code_sd}, {6'b0, bp, bc});
    endtask

    task automatic window(int n);
        @(negedge clk);
        strobe = 1'b1;
        wait_n(2);
        sample(0);
        for (int k = 1; k <= n; k++) begin
            pcm_sclk = 1'b0; code_sclk = 1'b0;
            wait_n(2);
            pcm_sclk = 1'b1; code_sclk = 1'b1;
            wait_n(2);
            sample(k);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        rst_n = 1'b0; strobe = 1'b0; pcm_sclk = 1'b1; code_sclk = 1'b1;
        dir_in = 0; law_in = 0; en_in = 0; rate_in = 0; pcm_in = 0; code_in = 0;
        wait_n(3);
        chk("R1", {6'b0, pcm_oe, code_oe}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        wait_n(2);
        // window before any load: nothing drives (R1)
        window(3);

        // directed corners
        load(8'hA6, 5'h00, 1'b0, 2'b00, 1'b0, 1'b1); window(10);  // R5 wrap
        load(8'h00, 5'h0B, 1'b1, 2'b00, 1'b0, 1'b1); window(8);   // R6 32k repeat
        load(8'h00, 5'h1D, 1'b1, 2'b01, 1'b0, 1'b1); window(6);   // R6 filler
        load(8'h00, 5'h1E, 1'b1, 2'b10, 1'b0, 1'b1); window(6);   // R6 filler
        load(8'h00, 5'h16, 1'b1, 2'b11, 1'b0, 1'b1); window(7);   // R7 wrap
        load(8'h3C, 5'h1F, 1'b0, 2'b00, 1'b0, 1'b0); window(9);   // R10 law0
        load(8'h3C, 5'h1F, 1'b0, 2'b00, 1'b1, 1'b0); window(9);   // R10 law1
        load(8'h3C, 5'h1F, 1'b1, 2'b11, 1'b1, 1'b0); window(6);   // R10 code idle
        load(8'h81, 5'h11, 1'b0, 2'b11, 1'b0, 1'b1); window(0);   // R3 no edges

        for (int i = 0; i < 40; i++) begin
            load(8'($urandom), 5'($urandom), 1'($urandom), 2'($urandom),
                 1'($urandom), ($urandom % 5) != 0);
            window($urandom % 13);
        end
        load(8'h00, 5'h00, 1'b0, 2'b00, 1'b0, 1'b1);
        finish_run();
    end
endmodule